// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the card-side bus clock of a memory-card host controller from a faster kernel clock. The kernel clock is divided by an 8-bit factor plus two. Alternatively, a bypass path hands the kernel rate straight to the card. The clock can be switched off entirely, or, in power-save mode, run only while the command and data path flags the bus as active.

The card clock is not a gated clock net. It is a registered level together with one-cycle strobes: a clock-enable strobe and rising and falling edge strobes. The command and data shifters use these strobes to move bits in step with the card clock. All logic runs in the kernel clock domain.

A single configuration word sets up the block and can be read back. After each accepted write, the block ignores further writes for a fixed lockout window and shows this on a busy flag. New divide, bypass, enable and power-save settings take effect only where a low phase ends, so the output never shows a shortened pulse.

Top module: `cardclk_gen`

## Requirements
- R1: After reset the configuration word reads 0, busy is low, and the level, the clock-enable strobe and both edge strobes are all 0.
- R2: With bypass clear and running, the ratio is R = divide + 2. Rising strobes come every R kernel cycles. The high phase lasts floor(R/2) cycles and the low phase lasts R - floor(R/2) cycles.
- R3: In divided mode the rising strobe is high for exactly the one cycle in which the level first reads 1. The falling strobe is high for exactly the one cycle in which the level first reads 0. The clock-enable strobe equals the rising strobe.
- R4: With bypass (bit 10) set and running, the level, both edge strobes and the clock-enable strobe are 1 in every cycle, whatever the divide factor.
- R5: With clock-enable (bit 8) at 0, the block stops at the end of the current low phase. The level then stays 0 and no strobe is issued.
- R6: With power-save (bit 9) set, the clock runs only while the bus-active input is 1. When that input drops, the clock stops at the end of the current low phase.
- R7: Suppose the block is stopped and the run condition becomes true at a clock edge. The block then issues a full low phase of R - floor(R/2) cycles, and its first rising strobe appears that many edges later.
- R8: A new divide factor is adopted only when a low phase ends. A high phase that is already under way, and the low phase after it, keep the old lengths.
- R9: An accepted write sets busy from the next cycle for 7 cycles. Writes presented during those cycles are ignored. The configuration word keeps its value while busy is high.
- R10: The read-back port returns the last accepted word with this layout: bit 10 bypass, bit 9 power-save, bit 8 clock-enable, bits 7:0 divide factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write request |
| cfg_wdata_i | input | 11 | Configuration word to write |
| cfg_rdata_o | output | 11 | Current configuration word |
| cfg_busy_o | output | 1 | Write lockout active |
| bus_active_i | input | 1 | Bus activity flag from the command and data path |
| cclk_o | output | 1 | Registered card clock level |
| cclk_en_o | output | 1 | One strobe per card clock period |
| cclk_rise_o | output | 1 | Rising edge strobe |
| cclk_fall_o | output | 1 | Falling edge strobe |

## Verification
A written word appears on the read-back port and raises busy in the sample right after the capturing edge. Busy then stays up for seven samples. Level and strobe changes appear one edge after the state that causes them. A new divide factor shows only after the next low-phase end. A restart rise lands exactly a low phase after the edge that first sees the run condition. The bench drives inputs and samples outputs on falling edges, and counts samples between events to compare phase lengths and latencies with values computed from the ratio.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_LOW  = 2'd1,
        MODE_HIGH = 2'd2,
        MODE_BYP  = 2'd3
    } mode_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
        logic en;
    } clk_out_t;

endpackage

// File: rtl/cardclk_cfg_reg.sv
module cardclk_cfg_reg #(
    parameter int DIV_W    = 8,
    parameter int LOCK_CYC = 7,
    localparam int CFG_W   = DIV_W + 3,
    localparam int LOCK_W  = $clog2(LOCK_CYC + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             busy_o
);

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [LOCK_W-1:0] lock;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.lock != '0) begin
            s_d.lock = s_q.lock - LOCK_W'(1);
        end else if (we_i) begin
            s_d.cfg  = wdata_i;
            s_d.lock = LOCK_W'(LOCK_CYC);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cfg_o  = s_q.cfg;
    assign busy_o = (s_q.lock != '0);

endmodule

// File: rtl/cardclk_gate.sv
module cardclk_gate (
    input  logic en_i,
    input  logic psave_i,
    input  logic active_i,
    output logic run_o
);

    always_comb begin
        run_o = en_i && (!psave_i || active_i);
    end

endmodule

// File: rtl/cardclk_phase.sv
module cardclk_phase
    import cardclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             byp_i,
    input  logic [DIV_W-1:0] div_i,
    output clk_out_t         out_o
);

    localparam logic [DIV_W:0] RAT_OFS = (DIV_W + 1)'(2);

    typedef struct packed {
        mode_e            mode;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        clk_out_t         out;
    } st_t;

    st_t s_d, s_q;

    // last count value of the high phase: floor(R/2) - 1
    function automatic logic [DIV_W-1:0] hi_last(input logic [DIV_W-1:0] d);
        logic [DIV_W:0] r;
        r = {1'b0, d} + RAT_OFS;
        return DIV_W'((r >> 1) - (DIV_W + 1)'(1));
    endfunction

    // last count value of the low phase: R - floor(R/2) - 1
    function automatic logic [DIV_W-1:0] lo_last(input logic [DIV_W-1:0] d);
        logic [DIV_W:0] r;
        r = {1'b0, d} + RAT_OFS;
        return DIV_W'(r - (r >> 1) - (DIV_W + 1)'(1));
    endfunction

    localparam clk_out_t OUT_BYP = '{lvl: 1'b1, rise: 1'b1, fall: 1'b1, en: 1'b1};

    always_comb begin
        s_d          = s_q;
        s_d.out.rise = 1'b0;
        s_d.out.fall = 1'b0;
        s_d.out.en   = 1'b0;
        unique case (s_q.mode)
            MODE_STOP: begin
                s_d.out.lvl = 1'b0;
                if (run_i) begin
                    if (byp_i) begin
                        s_d.mode = MODE_BYP;
                        s_d.out  = OUT_BYP;
                    end else begin
                        s_d.mode = MODE_LOW;
                        s_d.act  = div_i;
                        s_d.cnt  = lo_last(div_i);
                    end
                end
            end
            MODE_LOW: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - DIV_W'(1);
                end else if (!run_i) begin
                    s_d.mode    = MODE_STOP;
                    s_d.out.lvl = 1'b0;
                end else if (byp_i) begin
                    s_d.mode = MODE_BYP;
                    s_d.out  = OUT_BYP;
                end else begin
                    s_d.mode     = MODE_HIGH;
                    s_d.act      = div_i;
                    s_d.cnt      = hi_last(div_i);
                    s_d.out.lvl  = 1'b1;
                    s_d.out.rise = 1'b1;
                    s_d.out.en   = 1'b1;
                end
            end
            MODE_HIGH: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - DIV_W'(1);
                end else begin
                    s_d.mode     = MODE_LOW;
                    s_d.cnt      = lo_last(s_q.act);
                    s_d.out.lvl  = 1'b0;
                    s_d.out.fall = 1'b1;
                end
            end
            MODE_BYP: begin
                if (!run_i) begin
                    s_d.mode    = MODE_STOP;
                    s_d.out.lvl = 1'b0;
                end else if (byp_i) begin
                    s_d.out = OUT_BYP;
                end else begin
                    s_d.mode    = MODE_LOW;
                    s_d.act     = div_i;
                    s_d.cnt     = lo_last(div_i);
                    s_d.out.lvl = 1'b0;
                end
            end
            default: s_d.mode = MODE_STOP;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign out_o = s_q.out;

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int LOCK_CYC = 7,
    localparam int CFG_W   = DIV_W + 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    output logic             cfg_busy_o,
    input  logic             bus_active_i,
    output logic             cclk_o,
    output logic             cclk_en_o,
    output logic             cclk_rise_o,
    output logic             cclk_fall_o
);

    localparam int BIT_EN  = DIV_W;
    localparam int BIT_PS  = DIV_W + 1;
    localparam int BIT_BYP = DIV_W + 2;

    logic [CFG_W-1:0] cfg;
    logic             run;
    clk_out_t         cout;

    cardclk_cfg_reg #(.DIV_W(DIV_W), .LOCK_CYC(LOCK_CYC)) cfg_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg),
        .busy_o  (cfg_busy_o)
    );

    cardclk_gate gate_i (
        .en_i     (cfg[BIT_EN]),
        .psave_i  (cfg[BIT_PS]),
        .active_i (bus_active_i),
        .run_o    (run)
    );

    cardclk_phase #(.DIV_W(DIV_W)) phase_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .byp_i  (cfg[BIT_BYP]),
        .div_i  (cfg[DIV_W-1:0]),
        .out_o  (cout)
    );

    assign cfg_rdata_o = cfg;
    assign cclk_o      = cout.lvl;
    assign cclk_en_o   = cout.en;
    assign cclk_rise_o = cout.rise;
    assign cclk_fall_o = cout.fall;

endmodule

// File: rtl/cardclk_gen_chk.sv
module cardclk_gen_chk #(
    parameter int DIV_W    = 8,
    parameter int LOCK_CYC = 7
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cfg_we_i,
    input logic [DIV_W+2:0] cfg_rdata_o,
    input logic             cfg_busy_o,
    input logic             cclk_o,
    input logic             cclk_en_o,
    input logic             cclk_rise_o,
    input logic             cclk_fall_o
);

    assert_rise_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cclk_rise_o && !cclk_fall_o) |-> (cclk_o && !$past(cclk_o)));

    assert_fall_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cclk_fall_o && !cclk_rise_o) |-> (!cclk_o && $past(cclk_o)));

    assert_rose_has_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cclk_o) |-> cclk_rise_o);

    assert_en_with_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cclk_en_o |-> cclk_rise_o);

    assert_bypass_strobes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cclk_rise_o && cclk_fall_o) |-> (cclk_en_o && cclk_o));

    assert_lock_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && !cfg_busy_o) |=> cfg_busy_o);

    assert_lock_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_busy_o |=> $stable(cfg_rdata_o));

endmodule

bind cardclk_gen cardclk_gen_chk #(.DIV_W(DIV_W), .LOCK_CYC(LOCK_CYC)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_rdata_o (cfg_rdata_o),
    .cfg_busy_o  (cfg_busy_o),
    .cclk_o      (cclk_o),
    .cclk_en_o   (cclk_en_o),
    .cclk_rise_o (cclk_rise_o),
    .cclk_fall_o (cclk_fall_o)
);

// File: tb/cardclk_gen_tb_top.sv
module cardclk_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [10:0] wdata = '0;
    logic        bus_act = 1'b0;
    logic [10:0] rdata;
    logic        busy;
    logic        cclk, cen, rise, fall;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        string req;
        int    val;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    cardclk_gen dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_we_i     (we),
        .cfg_wdata_i  (wdata),
        .cfg_rdata_o  (rdata),
        .cfg_busy_o   (busy),
        .bus_active_i (bus_act),
        .cclk_o       (cclk),
        .cclk_en_o    (cen),
        .cclk_rise_o  (rise),
        .cclk_fall_o  (fall)
    );

    // driver side: queue what must be seen next
    task automatic push_exp(input string req, input int val);
        exp_q.push_back('{req: req, val: val});
    endtask

    // monitor side: pop and compare against what the design produced
    task automatic observe(input int act);
        exp_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard empty: got %0d expected none", act);
            return;
        end
        e = exp_q.pop_front();
        if (act != e.val) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", e.req, act, e.val);
        end
    endtask

    task automatic chk(input string req, input int act, input int val);
        push_exp(req, val);
        observe(act);
    endtask

    task automatic wr(input logic [10:0] v);
        while (busy) @(negedge clk);
        we    = 1'b1;
        wdata = v;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic wait_rise(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!rise && k < 2000);
    endtask

    task automatic meas_high(output int h);
        h = 0;
        while (cclk && h < 1000) begin
            h++;
            @(negedge clk);
        end
    endtask

    task automatic meas_low(output int l);
        l = 0;
        while (!cclk && l < 1000) begin
            l++;
            @(negedge clk);
        end
    endtask

    task automatic count_edges(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rise || fall || cen || cclk) c++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int k, h, l, c, bad, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 level", cclk, 0);
        chk("R1 strobes", rise + fall + cen, 0);
        chk("R1 readback", rdata, 0);
        chk("R1 busy", busy, 0);

        // R2: divide 0 -> ratio 2, high 1, low 1
        wr(11'h100);
        wait_rise(k);
        meas_high(h);
        meas_low(l);
        chk("R2 div0 high", h, 1);
        chk("R2 div0 low", l, 1);

        // R2: divide 3 -> ratio 5, high 2, low 3
        wr(11'h103);
        wait_rise(k);
        wait_rise(k);
        meas_high(h);
        meas_low(l);
        chk("R2 div3 high", h, 2);
        chk("R2 div3 low", l, 3);

        // R3: strobe alignment; R2: 8 rises in any 40-cycle window
        bad = 0;
        c = 0;
        prev = cclk;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rise) c++;
            if (rise && !(cclk && !prev)) bad++;
            if (fall && !(!cclk && prev)) bad++;
            if (cclk && !prev && !rise) bad++;
            if (!cclk && prev && !fall) bad++;
            if (cen != rise) bad++;
            prev = cclk;
        end
        chk("R3 strobe alignment errors", bad, 0);
        chk("R2 rises in 40 cycles", c, 8);

        // R2: divide 255 -> ratio 257, high 128, low 129
        wr(11'h1FF);
        wait_rise(k);
        wait_rise(k);
        meas_high(h);
        meas_low(l);
        chk("R2 div255 high", h, 128);
        chk("R2 div255 low", l, 129);

        // R8: change to divide 0 one cycle into a high phase
        wr(11'h100);
        meas_high(h);
        meas_low(l);
        chk("R8 running high keeps old length", h, 127);
        chk("R8 following low keeps old length", l, 129);
        meas_high(h);
        meas_low(l);
        chk("R8 new high", h, 1);
        chk("R8 new low", l, 1);

        // R4: bypass, divide factor 5 ignored
        wr(11'h505);
        repeat (15) @(negedge clk);
        c = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (rise && fall && cen && cclk) c++;
        end
        chk("R4 bypass strobe cycles", c, 10);

        // R5: enable clear stops the clock
        wr(11'h003);
        repeat (10) @(negedge clk);
        count_edges(50, c);
        chk("R5 activity while disabled", c, 0);

        // R6: power-save, bus idle -> stopped
        wr(11'h301);
        repeat (10) @(negedge clk);
        count_edges(30, c);
        chk("R6 activity while idle", c, 0);

        // R7: restart with full low phase (ratio 3, low 2)
        bus_act = 1'b1;
        wait_rise(k);
        chk("R7 samples to first rise", k, 3);
        meas_high(h);
        meas_low(l);
        chk("R6 active high", h, 1);
        chk("R6 active low", l, 2);
        bus_act = 1'b0;
        repeat (10) @(negedge clk);
        count_edges(20, c);
        chk("R6 stops after bus idle", c, 0);

        // R9: lockout window
        wr(11'h0A5);
        chk("R9 busy after write", busy, 1);
        chk("R10 readback first word", rdata, 11'h0A5);
        we    = 1'b1;
        wdata = 11'h7FF;
        @(negedge clk);
        we    = 1'b0;
        chk("R9 write ignored while busy", rdata, 11'h0A5);
        c = 0;
        while (busy && c < 100) begin
            c++;
            @(negedge clk);
        end
        chk("R9 remaining busy samples", c, 6);
        wr(11'h5C3);
        chk("R10 readback layout", rdata, 11'h5C3);
        chk("R10 bypass bit 10", rdata[10], 1);
        chk("R10 power-save bit 9", rdata[9], 0);
        chk("R10 divide bits 7:0", rdata[7:0], 8'hC3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule